// File: doc/BRIEF.md
# Audio Receive Word Packer

This block sits between a serial audio receiver and a 32-bit receive FIFO. Each time the receiver has shifted in a complete word, it hands the word over with a one-cycle strobe, together with the level of the channel-select line for that word. The packer then groups the words into stereo pairs. It can drop the leading word of a stream, can reverse the two members of a pair, and widens 16-bit samples to 32-bit lanes. The result is a stream of FIFO writes.

The configuration consists of a start rule, a pair-order bit and a 3-bit packing code. It is loaded while the enable input is low and held while enable is high, so software changes during a stream take no effect. The block watches the FIFO full input. A write offered while the FIFO is full is lost, and the loss is recorded in a sticky flag that a clear input resets.

Top module: `i2s_rx_packer`

## Requirements
- R1: In the 16-bit codes (0 and 1) the lane written is {sample[15:0], 16'h0000}. In the 32-bit codes (2 = paired, 3 = single) the sample is written unchanged.
- R2: Code values 4, 5, 6 and 7 give exactly the output of code 0 (16-bit, paired).
- R3: After enable rises, accepted words are skipped until the first word whose channel-select is 0. That word is the stream start. Channel-select is ignored after the start.
- R4: With the start-drop bit at 1, the stream-start word is discarded and the first pair is formed from the two words after it. With the bit at 0, the stream-start word is the first word of the first pair.
- R5: In the paired codes (0, 2) both words of a pair are written. With the order bit at 0 the earlier word is written first. With the order bit at 1 the later word is written first.
- R6: In the single codes (1, 3) one word is written per pair: the earlier word when the order bit is 0, the later word when it is 1. The other word is dropped.
- R7: A write appears in the cycle after the clock edge that accepted the word completing it. In the paired codes the two writes occupy consecutive cycles.
- R8: While the full input is high, the push output is low, the offered word is lost, and the overflow flag is 1 from the next cycle.
- R9: The overflow flag stays set until a cycle with the clear input high. If a clear and a lost write occur in the same cycle, the flag ends up set.
- R10: The configuration inputs are captured only on edges where enable is low. Changing them while enable is high does not alter the output.
- R11: Enable low, or the synchronous reset, returns pairing to the search for a stream start and discards any half-formed pair. Reset also clears the push output and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Stream enable; low = idle, configuration load |
| cfg_drop_first_i | input | 1 | Discard the stream-start word |
| cfg_swap_i | input | 1 | Pair order / single-channel word select |
| cfg_mode_i | input | 3 | Packing code |
| word_vld_i | input | 1 | One-cycle strobe per received word |
| word_data_i | input | 32 | Received word, sample right-aligned |
| word_ws_i | input | 1 | Channel-select level of the word |
| fifo_full_i | input | 1 | FIFO cannot accept a write |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| fifo_push_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 32 | FIFO write data |
| ovf_o | output | 1 | Sticky lost-write flag |

## Verification
Two functions of the overflow flag can fall in the same cycle: the clear request, and a write that is lost against a full FIFO. The bench sends one pair, waits until the first write of that pair is on the port, and then raises full and clear together for exactly that cycle. The expected result is that only the second write of the pair reaches the port and that the flag is still set afterwards. Around this case, the bench sweeps every packing code, both start rules and both pair orders, with changing gaps and leading words. During each of these runs it flips the configuration inputs while enable is high.

// File: rtl/i2s_rxp_pkg.sv
package i2s_rxp_pkg;

    localparam int MODE_W = 3;

    typedef struct packed {
        logic drop_first;
        logic swap;
        logic wide16;
        logic single;
    } rxp_cfg_t;

    typedef enum logic [1:0] {
        SL_SEEK   = 2'd0,
        SL_FIRST  = 2'd1,
        SL_SECOND = 2'd2
    } slot_e;

    function automatic rxp_cfg_t decode_cfg(input logic drop_first,
                                            input logic swap,
                                            input logic [MODE_W-1:0] mode);
        rxp_cfg_t c;
        c.drop_first = drop_first;
        c.swap       = swap;
        unique case (mode)
            3'd1:    begin c.wide16 = 1'b1; c.single = 1'b1; end
            3'd2:    begin c.wide16 = 1'b0; c.single = 1'b0; end
            3'd3:    begin c.wide16 = 1'b0; c.single = 1'b1; end
            default: begin c.wide16 = 1'b1; c.single = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/i2s_rxp_cfg.sv
module i2s_rxp_cfg
    import i2s_rxp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              drop_first_i,
    input  logic              swap_i,
    input  logic [MODE_W-1:0] mode_i,
    output rxp_cfg_t          cfg_o
);

    rxp_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!en_i) begin
            cfg_d = decode_cfg(drop_first_i, swap_i, mode_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= decode_cfg(1'b0, 1'b0, '0);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R10: configuration frozen across a running stream
    a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && $past(en_i)) |-> $stable(cfg_q));

endmodule

// File: rtl/i2s_rxp_slot.sv
module i2s_rxp_slot
    import i2s_rxp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic vld_i,
    input  logic ws_i,
    input  logic drop_first_i,
    output logic slot_first_o,
    output logic slot_second_o
);

    typedef struct packed {
        slot_e st;
    } slot_st_t;

    slot_st_t s_d, s_q;
    logic     first_c, second_c;

    always_comb begin
        s_d      = s_q;
        first_c  = 1'b0;
        second_c = 1'b0;
        if (!en_i) begin
            s_d.st = SL_SEEK;
        end else if (vld_i) begin
            unique case (s_q.st)
                SL_SEEK: begin
                    if (!ws_i) begin
                        if (drop_first_i) begin
                            s_d.st = SL_FIRST;
                        end else begin
                            first_c = 1'b1;
                            s_d.st  = SL_SECOND;
                        end
                    end
                end
                SL_FIRST: begin
                    first_c = 1'b1;
                    s_d.st  = SL_SECOND;
                end
                SL_SECOND: begin
                    second_c = 1'b1;
                    s_d.st   = SL_FIRST;
                end
                default: s_d.st = SL_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.st <= SL_SEEK;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_first_o  = first_c;
    assign slot_second_o = second_c;

    // R3: words with channel-select 1 never end the search
    a_r3_seek_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && vld_i && ws_i && s_q.st == SL_SEEK) |=> (s_q.st == SL_SEEK));

    // R4: a dropped start word leaves the sequencer waiting for a pair's first word
    a_r4_drop_start: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && vld_i && !ws_i && drop_first_i && s_q.st == SL_SEEK) |=> (s_q.st == SL_FIRST));

    // R11: enable low returns to the search
    a_r11_idle_seek: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (s_q.st == SL_SEEK));

endmodule

// File: rtl/i2s_rxp_lane.sv
module i2s_rxp_lane #(
    parameter int LANE_W = 32
) (
    input  logic              wide16_i,
    input  logic [LANE_W-1:0] word_i,
    output logic [LANE_W-1:0] lane_o
);

    localparam int HALF_W = LANE_W / 2;

    logic [LANE_W-1:0] packed_half;

    generate
        if (HALF_W > 0) begin : g_half
            assign packed_half = {word_i[HALF_W-1:0], {HALF_W{1'b0}}};
        end else begin : g_none
            assign packed_half = word_i;
        end
    endgenerate

    always_comb begin
        lane_o = wide16_i ? packed_half : word_i;
    end

endmodule

// File: rtl/i2s_rxp_out.sv
module i2s_rxp_out
    import i2s_rxp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  rxp_cfg_t          cfg_i,
    input  logic              slot_first_i,
    input  logic              slot_second_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              fifo_full_i,
    input  logic              ovf_clr_i,
    output logic              push_o,
    output logic [LANE_W-1:0] data_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [LANE_W-1:0] hold;
        logic              pend_vld;
        logic [LANE_W-1:0] pend;
        logic              push;
        logic [LANE_W-1:0] data;
        logic              ovf;
    } out_st_t;

    out_st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.push     = 1'b0;
        s_d.pend_vld = 1'b0;

        if (s_q.pend_vld) begin
            s_d.push = 1'b1;
            s_d.data = s_q.pend;
        end

        if (slot_first_i) begin
            s_d.hold = lane_i;
            if (cfg_i.single && !cfg_i.swap) begin
                s_d.push = 1'b1;
                s_d.data = lane_i;
            end
        end

        if (slot_second_i) begin
            if (cfg_i.single) begin
                if (cfg_i.swap) begin
                    s_d.push = 1'b1;
                    s_d.data = lane_i;
                end
            end else begin
                s_d.push     = 1'b1;
                s_d.data     = cfg_i.swap ? lane_i : s_q.hold;
                s_d.pend_vld = 1'b1;
                s_d.pend     = cfg_i.swap ? s_q.hold : lane_i;
            end
        end

        s_d.ovf = (s_q.ovf && !ovf_clr_i) || (s_q.push && fifo_full_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign push_o = s_q.push && !fifo_full_i;
    assign data_o = s_q.data;
    assign ovf_o  = s_q.ovf;

    // R7: a completed pair in a paired code gives writes on two consecutive cycles
    a_r7_pair_back_to_back: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot_second_i && !cfg_i.single) |=> (s_q.push ##1 s_q.push));

    // R6: single codes never write on two consecutive cycles
    a_r6_single_spaced: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_i.single && s_q.push) |=> !s_q.push);

    // R8: a write met by a full FIFO raises the flag
    a_r8_lost_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.push && fifo_full_i) |=> s_q.ovf);

    // R9: the flag only falls on a clear
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.ovf && !ovf_clr_i) |=> s_q.ovf);

endmodule

// File: rtl/i2s_rx_packer.sv
module i2s_rx_packer
    import i2s_rxp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              cfg_drop_first_i,
    input  logic              cfg_swap_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              word_vld_i,
    input  logic [LANE_W-1:0] word_data_i,
    input  logic              word_ws_i,
    input  logic              fifo_full_i,
    input  logic              ovf_clr_i,
    output logic              fifo_push_o,
    output logic [LANE_W-1:0] fifo_data_o,
    output logic              ovf_o
);

    rxp_cfg_t          cfg;
    logic              slot_first, slot_second;
    logic [LANE_W-1:0] lane;

    i2s_rxp_cfg u_cfg (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .en_i         (en_i),
        .drop_first_i (cfg_drop_first_i),
        .swap_i       (cfg_swap_i),
        .mode_i       (cfg_mode_i),
        .cfg_o        (cfg)
    );

    i2s_rxp_slot u_slot (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .en_i          (en_i),
        .vld_i         (word_vld_i),
        .ws_i          (word_ws_i),
        .drop_first_i  (cfg.drop_first),
        .slot_first_o  (slot_first),
        .slot_second_o (slot_second)
    );

    i2s_rxp_lane #(.LANE_W(LANE_W)) u_lane (
        .wide16_i (cfg.wide16),
        .word_i   (word_data_i),
        .lane_o   (lane)
    );

    i2s_rxp_out #(.LANE_W(LANE_W)) u_out (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .cfg_i         (cfg),
        .slot_first_i  (slot_first),
        .slot_second_i (slot_second),
        .lane_i        (lane),
        .fifo_full_i   (fifo_full_i),
        .ovf_clr_i     (ovf_clr_i),
        .push_o        (fifo_push_o),
        .data_o        (fifo_data_o),
        .ovf_o         (ovf_o)
    );

endmodule

// File: tb/i2s_rx_packer_tb.sv
module i2s_rx_packer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        drop_first = 1'b0;
    logic        swap = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        vld = 1'b0;
    logic [31:0] wdata = '0;
    logic        ws = 1'b0;
    logic        full = 1'b0;
    logic        clr = 1'b0;
    logic        push;
    logic [31:0] pdata;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    logic [31:0] rec [0:511];
    int rec_n = 0;
    logic [31:0] sw [0:63];
    logic [31:0] expw [0:63];

    always #5 clk = ~clk;

    i2s_rx_packer u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en),
        .cfg_drop_first_i(drop_first), .cfg_swap_i(swap), .cfg_mode_i(mode),
        .word_vld_i(vld), .word_data_i(wdata), .word_ws_i(ws),
        .fifo_full_i(full), .ovf_clr_i(clr),
        .fifo_push_o(push), .fifo_data_o(pdata), .ovf_o(ovf)
    );

    // record every write, 1 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (push && rec_n < 512) begin
                rec[rec_n] = pdata;
                rec_n = rec_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input logic [31:0] d, input logic w);
        vld = 1'b1; wdata = d; ws = w;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] m, input logic rf, input logic mr);
        en = 1'b0; mode = m; drop_first = rf; swap = mr;
        idle(2);
    endtask

    function automatic logic [31:0] fmt(input logic [2:0] m, input logic [31:0] x);
        if (m == 3'd2 || m == 3'd3) return x;
        return {x[15:0], 16'h0000};
    endfunction

    task automatic run_case(input logic [2:0] m, input logic rf, input logic mr,
                            input int nlead, input int npairs, input int gapsel, input int run);
        int nw, base, ne, start;
        bit single;
        string tag;
        set_cfg(m, rf, mr);
        base = rec_n;
        en = 1'b1;
        // R10: flip every configuration input while the stream runs
        mode = m ^ 3'b011; drop_first = ~rf; swap = ~mr;
        nw = nlead + (rf ? 1 : 0) + 2 * npairs;
        for (int k = 0; k < nw; k++) begin
            sw[k] = (32'h9E37_79B9 * (k + 1)) ^ (run << 8);
            put(sw[k], (k < nlead) ? 1'b1 : (((k - nlead) % 2) == 1));
            idle((k * gapsel) % 3);
        end
        idle(4);
        en = 1'b0;
        single = (m == 3'd1 || m == 3'd3);
        start = nlead + (rf ? 1 : 0);
        ne = 0;
        for (int j = 0; j < npairs; j++) begin
            if (single) begin
                expw[ne] = fmt(m, mr ? sw[start + 2*j + 1] : sw[start + 2*j]); ne++;
            end else begin
                expw[ne] = fmt(m, mr ? sw[start + 2*j + 1] : sw[start + 2*j]); ne++;
                expw[ne] = fmt(m, mr ? sw[start + 2*j] : sw[start + 2*j + 1]); ne++;
            end
        end
        chk((rec_n - base) == ne, "R10", rec_n - base, ne);
        for (int j = 0; j < ne && (base + j) < rec_n; j++) begin
            if (j == 0 && nlead > 0) tag = "R3";
            else if (m >= 3'd4) tag = "R2";
            else if (j == 0 && rf) tag = "R4";
            else if (single) tag = "R6";
            else tag = "R5";
            chk(rec[base + j] === expw[j], tag, rec[base + j], expw[j]);
            if (m != 3'd2 && m != 3'd3)
                chk(rec[base + j][15:0] == 16'h0, "R1", rec[base + j], expw[j]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        #1;
        chk(push == 1'b0, "R11", push, 0);
        chk(ovf == 1'b0, "R11", ovf, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // sweep: every code, both start rules, both orders
        for (int m = 0; m < 8; m++)
            for (int rf = 0; rf < 2; rf++)
                for (int mr = 0; mr < 2; mr++)
                    run_case(m[2:0], rf[0], mr[0], m % 3, 3, m + rf, m * 4 + rf * 2 + mr);

        // R1: explicit 16-bit widening value
        set_cfg(3'd1, 1'b0, 1'b0);
        base = rec_n; en = 1'b1;
        put(32'h1234_FEDC, 1'b0); put(32'h5555_AAAA, 1'b1); idle(3);
        chk(rec_n - base == 1 && rec[base] == 32'hFEDC_0000, "R1", rec[base], 32'hFEDC_0000);

        // R7: exact write cycles in a paired code
        set_cfg(3'd2, 1'b0, 1'b1);
        en = 1'b1;
        put(32'hA0A0_0001, 1'b0); put(32'hB0B0_0002, 1'b1);
        #4;
        chk(push && pdata == 32'hB0B0_0002, "R7", pdata, 32'hB0B0_0002);
        @(negedge clk); #4;
        chk(push && pdata == 32'hA0A0_0001, "R7", pdata, 32'hA0A0_0001);
        @(negedge clk); #4;
        chk(push == 1'b0, "R7", push, 0);
        @(negedge clk);

        // R11: enable low drops a half pair
        set_cfg(3'd2, 1'b0, 1'b0);
        base = rec_n; en = 1'b1;
        put(32'hDEAD_0001, 1'b0);
        en = 1'b0; idle(2); en = 1'b1;
        put(32'h1111_0001, 1'b0); put(32'h2222_0002, 1'b1); idle(3);
        chk(rec_n - base == 2 && rec[base] == 32'h1111_0001 && rec[base+1] == 32'h2222_0002,
            "R11", rec[base], 32'h1111_0001);

        // R11: synchronous reset drops a half pair (code 0 after reset)
        set_cfg(3'd0, 1'b0, 1'b0);
        base = rec_n; en = 1'b1;
        put(32'hDEAD_0003, 1'b0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        put(32'h3333_1234, 1'b0); put(32'h4444_5678, 1'b1); idle(3);
        chk(rec_n - base == 2 && rec[base] == 32'h1234_0000 && rec[base+1] == 32'h5678_0000,
            "R11", rec[base], 32'h1234_0000);

        // R8: both writes of a pair lost against a full FIFO
        set_cfg(3'd2, 1'b0, 1'b0);
        base = rec_n; en = 1'b1; full = 1'b1;
        put(32'h0000_00A1, 1'b0); put(32'h0000_00B2, 1'b1); idle(3);
        full = 1'b0;
        chk(rec_n - base == 0, "R8", rec_n - base, 0);
        #1; chk(ovf == 1'b1, "R8", ovf, 1);
        // R9: sticky, then cleared
        idle(3); #1;
        chk(ovf == 1'b1, "R9", ovf, 1);
        @(negedge clk);
        clr = 1'b1; @(negedge clk); clr = 1'b0; #1;
        chk(ovf == 1'b0, "R9", ovf, 0);
        @(negedge clk);

        // R9: clear and lost write in the same cycle, set wins
        base = rec_n;
        put(32'h0000_00C3, 1'b0); put(32'h0000_00D4, 1'b1);
        full = 1'b1; clr = 1'b1;
        @(negedge clk);
        full = 1'b0; clr = 1'b0;
        idle(3); #1;
        chk(rec_n - base == 1 && rec[base] == 32'h0000_00D4, "R9", rec[base], 32'h0000_00D4);
        chk(ovf == 1'b1, "R9", ovf, 1);

        // R11: reset clears the flag
        @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
        chk(ovf == 1'b0 && push == 1'b0, "R11", ovf, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule